// File: doc/BRIEF.md
# Split or Unified Event-Controlled Counter

This block is a free-running counter that can be configured either as one 32-bit counter or as two independent 16-bit counters, a low half and a high half. Each half has its own stop and halt control bits and advances only while both bits are clear. A programmable start mask selects which incoming event pulses clear a half's stop bit. Halt can only be changed by software. Each half also carries a small software-defined state value.

Software reaches the count, state, start-mask, control and configuration registers through a simple request/response register port. A write to a count or state register is accepted only while the counter it affects is halted. Otherwise the write is dropped and the response flags an error. The port has no back-pressure: a request is taken in any cycle in which `req_valid` is high, and exactly one response (`rsp_valid` high) follows in the next cycle. The halfword selects `req_hsel[0]` (bits 15:0) and `req_hsel[1]` (bits 31:16) choose which halves a write touches. Reads always return the full word. Register addresses are: 0 control, 1 configuration, 2 start mask, 3 count, 4 state. Other addresses read as zero, ignore writes and never flag an error.

Top module: `evctr_top`

## Requirements
- R1: After reset the control register reads 0x00030003 (stop and halt set in both halves), and the configuration, start-mask, count and state registers all read 0.
- R2: A half advances by one on each clock edge only while both its stop bit (bit 0 of its control halfword) and its halt bit (bit 1 of its control halfword) are 0. If either bit is set, the count holds.
- R3: With configuration bit 0 (unify) set, the count register is one 32-bit counter in which the carry out of bit 15 feeds bit 16. Only the low control bits and the low start-mask bits govern it. The high stop and halt bits and the high mask bits have no effect.
- R4: With unify clear, the two 16-bit halves count independently, each under its own control bits, and each wraps from 0xFFFF to 0x0000 with no carry into the other half.
- R5: Start-mask bit n (bits 15:0) makes event n clear the low stop bit, and bit 16+n makes event n clear the high stop bit (the latter only when unify is clear). Several masked events in one cycle act as one start event, and unmasked events do nothing.
- R6: A start event never changes a halt bit.
- R7: A write to the count register is accepted only if every selected half's governing halt bit is 1. In unified mode the governing bit is the low halt bit for both halves. A rejected write changes nothing and is answered with rsp_err = 1. An accepted write updates only the selected halfwords.
- R8: A write to the state register follows the same halt rule and error response as R7. The state register can be read at any time.
- R9: Reads of any register, including the count of a running counter, always return rsp_err = 0.
- R10: When a control write to a half and a start event for that half occur in the same cycle, the written value decides the stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 16 | Event pulses, one bit per event, each one cycle wide |
| req_valid | input | 1 | Register request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_hsel | input | 2 | Halfword selects for writes: bit 0 = bits 15:0, bit 1 = bits 31:16 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Bus error: the previous write was rejected |
| rsp_rdata | output | 32 | Read data for the previous request (0 for writes) |

## Verification
The assertions take for granted that each request is held for a single cycle and that the event inputs are single-cycle pulses, so a start event is seen at one clock edge only. They also take for granted that reset is applied before any request is issued. The stimulus drives every request and event at the falling clock edge, holds it for exactly one rising edge and then returns it to idle. No request is issued while reset is active. The expected count values are derived by counting the rising edges between the edge that releases a counter and the edge that halts it again.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_CFG   = 3'd1,
    RA_START = 3'd2,
    RA_COUNT = 3'd3,
    RA_STATE = 3'd4
  } reg_addr_e;

  localparam int CTL_STOP = 0;
  localparam int CTL_HALT = 1;
  localparam int CFG_UNIFY = 0;
endpackage

// File: rtl/evctr_half.sv
module evctr_half #(
  parameter int HW  = 16,
  parameter int EVW = 16,
  parameter int STW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  input  logic           ev_en,
  input  logic [EVW-1:0] ev,
  input  logic           cnt_we,
  input  logic [HW-1:0]  cnt_wd,
  input  logic           st_we,
  input  logic [STW-1:0] st_wd,
  input  logic           ctl_we,
  input  logic           ctl_stop_wd,
  input  logic           ctl_halt_wd,
  input  logic           msk_we,
  input  logic [EVW-1:0] msk_wd,
  output logic [HW-1:0]  cnt,
  output logic [STW-1:0] state,
  output logic           stop,
  output logic           halt,
  output logic [EVW-1:0] mask,
  output logic           hit
);
  assign hit = ev_en && (|(ev & mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      state <= '0;
      stop  <= 1'b1;
      halt  <= 1'b1;
      mask  <= '0;
    end else begin
      if (cnt_we)   cnt <= cnt_wd;
      else if (inc) cnt <= cnt + 1'b1;
      if (st_we)    state <= st_wd;
      if (msk_we)   mask <= msk_wd;
      if (ctl_we) begin
        stop <= ctl_stop_wd;
        halt <= ctl_halt_wd;
      end else if (hit) begin
        stop <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/evctr_bus.sv
module evctr_bus
  import evctr_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_wr,
  input  logic [2:0]      req_addr,
  input  logic [1:0]      req_hsel,
  input  logic            unify,
  input  logic [1:0]      halt_h,
  input  logic [2*HW-1:0] ctrl_word,
  input  logic [2*HW-1:0] cfg_word,
  input  logic [2*HW-1:0] mask_word,
  input  logic [2*HW-1:0] cnt_word,
  input  logic [2*HW-1:0] state_word,
  output logic [1:0]      cnt_we,
  output logic [1:0]      st_we,
  output logic [1:0]      ctl_we,
  output logic [1:0]      msk_we,
  output logic            cfg_we,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [2*HW-1:0] rsp_rdata
);
  localparam int DW = 2 * HW;

  logic       wr_go;
  logic [1:0] guard;
  logic       guarded_addr;
  logic       blocked;
  logic [DW-1:0] rd_mux;

  assign wr_go        = req_valid && req_wr;
  assign guard        = unify ? {2{halt_h[0]}} : halt_h;
  assign guarded_addr = (req_addr == RA_COUNT) || (req_addr == RA_STATE);
  assign blocked      = wr_go && guarded_addr && (|(req_hsel & ~guard));

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      cnt_we[h] = wr_go && !blocked && req_hsel[h] && (req_addr == RA_COUNT);
      st_we[h]  = wr_go && !blocked && req_hsel[h] && (req_addr == RA_STATE);
      ctl_we[h] = wr_go && req_hsel[h] && (req_addr == RA_CTRL);
      msk_we[h] = wr_go && req_hsel[h] && (req_addr == RA_START);
    end
    cfg_we = wr_go && req_hsel[0] && (req_addr == RA_CFG);
  end

  always_comb begin
    case (req_addr)
      RA_CTRL:  rd_mux = ctrl_word;
      RA_CFG:   rd_mux = cfg_word;
      RA_START: rd_mux = mask_word;
      RA_COUNT: rd_mux = cnt_word;
      RA_STATE: rd_mux = state_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= blocked;
      rsp_rdata <= (req_valid && !req_wr) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/evctr_top.sv
module evctr_top
  import evctr_pkg::*;
#(
  parameter int HW  = 16,
  parameter int EVW = 16,
  parameter int STW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EVW-1:0]  ev_pulse,
  input  logic            req_valid,
  input  logic            req_wr,
  input  logic [2:0]      req_addr,
  input  logic [1:0]      req_hsel,
  input  logic [2*HW-1:0] req_wdata,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [2*HW-1:0] rsp_rdata
);
  localparam int DW = 2 * HW;

  logic [1:0][HW-1:0]  cnt_h;
  logic [1:0][STW-1:0] state_h;
  logic [1:0][EVW-1:0] mask_h;
  logic [1:0]          stop_h, halt_h, hit_h, inc_h, ev_en_h;
  logic [1:0]          cnt_we, st_we, ctl_we, msk_we;
  logic                cfg_we;
  logic                unify;
  logic [DW-1:0]       ctrl_word, cfg_word, mask_word, cnt_word, state_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unify <= 1'b0;
    else if (cfg_we) unify <= req_wdata[CFG_UNIFY];
  end

  assign inc_h[0]   = !stop_h[0] && !halt_h[0];
  assign inc_h[1]   = unify ? (inc_h[0] && (&cnt_h[0])) : (!stop_h[1] && !halt_h[1]);
  assign ev_en_h[0] = 1'b1;
  assign ev_en_h[1] = !unify;

  for (genvar h = 0; h < 2; h++) begin : g_half
    evctr_half #(.HW(HW), .EVW(EVW), .STW(STW)) u_half (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc         (inc_h[h]),
      .ev_en       (ev_en_h[h]),
      .ev          (ev_pulse),
      .cnt_we      (cnt_we[h]),
      .cnt_wd      (req_wdata[h*HW +: HW]),
      .st_we       (st_we[h]),
      .st_wd       (req_wdata[h*HW +: STW]),
      .ctl_we      (ctl_we[h]),
      .ctl_stop_wd (req_wdata[h*HW + CTL_STOP]),
      .ctl_halt_wd (req_wdata[h*HW + CTL_HALT]),
      .msk_we      (msk_we[h]),
      .msk_wd      (req_wdata[h*HW +: EVW]),
      .cnt         (cnt_h[h]),
      .state       (state_h[h]),
      .stop        (stop_h[h]),
      .halt        (halt_h[h]),
      .mask        (mask_h[h]),
      .hit         (hit_h[h])
    );
  end

  always_comb begin
    ctrl_word  = '0;
    mask_word  = '0;
    state_word = '0;
    for (int h = 0; h < 2; h++) begin
      ctrl_word[h*HW + CTL_STOP] = stop_h[h];
      ctrl_word[h*HW + CTL_HALT] = halt_h[h];
      mask_word[h*HW +: EVW]     = mask_h[h];
      state_word[h*HW +: STW]    = state_h[h];
    end
    cfg_word            = '0;
    cfg_word[CFG_UNIFY] = unify;
    cnt_word            = cnt_h;
  end

  evctr_bus #(.HW(HW)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_wr     (req_wr),
    .req_addr   (req_addr),
    .req_hsel   (req_hsel),
    .unify      (unify),
    .halt_h     (halt_h),
    .ctrl_word  (ctrl_word),
    .cfg_word   (cfg_word),
    .mask_word  (mask_word),
    .cnt_word   (cnt_word),
    .state_word (state_word),
    .cnt_we     (cnt_we),
    .st_we      (st_we),
    .ctl_we     (ctl_we),
    .msk_we     (msk_we),
    .cfg_we     (cfg_we),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/evctr_chk.sv
module evctr_chk
  import evctr_pkg::*;
#(
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_wr,
  input logic [2:0]    req_addr,
  input logic [1:0]    req_hsel,
  input logic          req_wdata0,
  input logic          rsp_err,
  input logic          unify,
  input logic [HW-1:0] cnt_lo,
  input logic [HW-1:0] cnt_hi,
  input logic          stop_lo,
  input logic          halt_lo,
  input logic          stop_hi,
  input logic          halt_hi,
  input logic          hit_lo
);
  logic ctl_wr_lo, cnt_wr_lo, cnt_wr_hi, cnt_wr_any;
  assign ctl_wr_lo  = req_valid && req_wr && (req_addr == RA_CTRL)  && req_hsel[0];
  assign cnt_wr_lo  = req_valid && req_wr && (req_addr == RA_COUNT) && req_hsel[0];
  assign cnt_wr_hi  = req_valid && req_wr && (req_addr == RA_COUNT) && req_hsel[1];
  assign cnt_wr_any = cnt_wr_lo || cnt_wr_hi;

  a_r6_halt_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_lo && !ctl_wr_lo) |=> halt_lo);

  a_r2_lo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_lo || stop_lo) && !cnt_wr_lo) |=> $stable(cnt_lo));

  a_r7_err_running: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_lo && !halt_lo) |=> rsp_err);

  a_r9_read_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_wr) |=> !rsp_err);

  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && !ctl_wr_lo) |=> !stop_lo);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && ctl_wr_lo) |=> (stop_lo == $past(req_wdata0)));

  a_r3_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (unify && !stop_lo && !halt_lo && (&cnt_lo) && !cnt_wr_any)
      |=> (cnt_hi == HW'($past(cnt_hi) + 1'b1)));

  a_r4_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!unify && (halt_hi || stop_hi) && !cnt_wr_hi) |=> $stable(cnt_hi));
endmodule

bind evctr_top evctr_chk #(.HW(HW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_wr     (req_wr),
  .req_addr   (req_addr),
  .req_hsel   (req_hsel),
  .req_wdata0 (req_wdata[0]),
  .rsp_err    (rsp_err),
  .unify      (unify),
  .cnt_lo     (cnt_h[0]),
  .cnt_hi     (cnt_h[1]),
  .stop_lo    (stop_h[0]),
  .halt_lo    (halt_h[0]),
  .stop_hi    (stop_h[1]),
  .halt_hi    (halt_h[1]),
  .hit_lo     (hit_h[0])
);

// File: tb/evctr_top_tb.sv
module evctr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev_pulse = '0;
  logic        req_valid = 1'b0;
  logic        req_wr = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [1:0]  req_hsel = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evctr_top u_dut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse),
    .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
    .req_hsel(req_hsel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [1:0]  hsel;
    logic [31:0] wd;
    logic        err;
    logic        chk;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd0, 2'b11, 32'h0,        1'b0, 1'b1, 32'h00030003}, // R1 ctrl
    '{1'b0, 3'd3, 2'b11, 32'h0,        1'b0, 1'b1, 32'h00000000}, // R1 count
    '{1'b0, 3'd2, 2'b11, 32'h0,        1'b0, 1'b1, 32'h00000000}, // R1 mask
    '{1'b0, 3'd4, 2'b11, 32'h0,        1'b0, 1'b1, 32'h00000000}, // R1 state
    '{1'b0, 3'd1, 2'b11, 32'h0,        1'b0, 1'b1, 32'h00000000}, // R1 config
    '{1'b1, 3'd3, 2'b11, 32'h1234ABCD, 1'b0, 1'b0, 32'h0},        // R7 halted write
    '{1'b0, 3'd3, 2'b11, 32'h0,        1'b0, 1'b1, 32'h1234ABCD}, // R7
    '{1'b1, 3'd4, 2'b01, 32'h00000007, 1'b0, 1'b0, 32'h0},        // R8 halted write
    '{1'b0, 3'd4, 2'b11, 32'h0,        1'b0, 1'b1, 32'h00000007}, // R8
    '{1'b1, 3'd3, 2'b10, 32'hFFFF0000, 1'b0, 1'b0, 32'h0},        // R7 high half only
    '{1'b0, 3'd3, 2'b11, 32'h0,        1'b0, 1'b1, 32'hFFFFABCD}  // R7
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Request driven at a falling edge, taken at the next rising edge,
  // response sampled at the falling edge after it.
  task automatic bus(input logic wr, input logic [2:0] addr, input logic [1:0] hsel,
                     input logic [31:0] wd, output logic err, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = addr; req_hsel = hsel; req_wdata = wd;
    @(negedge clk);
    err = rsp_err; rd = rsp_rdata;
    req_valid = 1'b0; req_wr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] ev);
    @(negedge clk);
    ev_pulse = ev;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic e;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(TBL[i].wr, TBL[i].addr, TBL[i].hsel, TBL[i].wd, e, d);
      check($sformatf("R7 R8 R1 vec%0d err", i), {31'b0, e}, {31'b0, TBL[i].err});
      if (TBL[i].chk) check($sformatf("R1 R7 R8 vec%0d rdata", i), d, TBL[i].rd);
    end

    // R4 R2: low runs two edges from 0xFFFE and wraps, high halted and untouched
    bus(1, 3'd3, 2'b11, 32'h0010FFFE, e, d);
    bus(1, 3'd0, 2'b01, 32'h0, e, d);
    bus(1, 3'd0, 2'b01, 32'h2, e, d);
    bus(0, 3'd3, 2'b11, 32'h0, e, d);
    check("R4 split wrap", d, 32'h00100000);

    // R7: write while running is rejected; 4 edges counted
    bus(1, 3'd0, 2'b01, 32'h0, e, d);
    bus(1, 3'd3, 2'b01, 32'h00005555, e, d);
    check("R7 running write err", {31'b0, e}, 32'h1);
    bus(1, 3'd0, 2'b01, 32'h2, e, d);
    bus(0, 3'd3, 2'b11, 32'h0, e, d);
    check("R7 discarded data", d, 32'h00100004);

    // R5 R6: start masks
    bus(1, 3'd0, 2'b11, 32'h00030003, e, d);
    bus(1, 3'd2, 2'b11, 32'h00200008, e, d);
    pulse(16'h0010);
    bus(0, 3'd0, 2'b11, 32'h0, e, d);
    check("R5 unmasked event", d, 32'h00030003);
    pulse(16'h0088);
    bus(0, 3'd0, 2'b11, 32'h0, e, d);
    check("R5 R6 low stop cleared halt kept", d, 32'h00030002);
    pulse(16'h0020);
    bus(0, 3'd0, 2'b11, 32'h0, e, d);
    check("R5 R6 high stop cleared", d, 32'h00020002);
    bus(0, 3'd3, 2'b11, 32'h0, e, d);
    check("R6 halted count held", d, 32'h00100004);

    // R2 R5: stop alone freezes; event releases, 2 edges counted
    bus(1, 3'd0, 2'b01, 32'h1, e, d);
    repeat (3) @(negedge clk);
    bus(0, 3'd3, 2'b11, 32'h0, e, d);
    check("R2 stop freezes", d, 32'h00100004);
    pulse(16'h0008);
    bus(1, 3'd0, 2'b01, 32'h2, e, d);
    bus(0, 3'd3, 2'b11, 32'h0, e, d);
    check("R5 event release", d, 32'h00100006);

    // R10: control write and start event in the same cycle
    @(negedge clk);
    ev_pulse = 16'h0008;
    req_valid = 1'b1; req_wr = 1'b1; req_addr = 3'd0; req_hsel = 2'b01; req_wdata = 32'h3;
    @(negedge clk);
    ev_pulse = '0; req_valid = 1'b0; req_wr = 1'b0;
    bus(0, 3'd0, 2'b11, 32'h0, e, d);
    check("R10 write wins", d, 32'h00020003);

    // R3: unified carry with high controls halted
    bus(1, 3'd1, 2'b01, 32'h1, e, d);
    bus(1, 3'd3, 2'b11, 32'h0000FFFE, e, d);
    check("R3 unified halted write", {31'b0, e}, 32'h0);
    bus(1, 3'd0, 2'b11, 32'h00030000, e, d);
    bus(1, 3'd0, 2'b01, 32'h2, e, d);
    bus(0, 3'd3, 2'b11, 32'h0, e, d);
    check("R3 carry into bit 16", d, 32'h00010000);

    // R3 R7 R9: high-half write gated by low halt; read while running
    bus(1, 3'd0, 2'b01, 32'h0, e, d);
    bus(1, 3'd3, 2'b10, 32'hAAAA0000, e, d);
    check("R3 R7 unified hi write err", {31'b0, e}, 32'h1);
    bus(0, 3'd3, 2'b11, 32'h0, e, d);
    check("R9 running read err", {31'b0, e}, 32'h0);
    check("R9 running read data", d, 32'h00010003);
    bus(1, 3'd0, 2'b01, 32'h2, e, d);
    bus(0, 3'd3, 2'b11, 32'h0, e, d);
    check("R3 unified count", d, 32'h00010006);
    pulse(16'h0020);
    bus(0, 3'd0, 2'b11, 32'h0, e, d);
    check("R3 high mask ignored", d, 32'h00030002);

    // R8: state write while running is rejected
    bus(1, 3'd0, 2'b01, 32'h0, e, d);
    bus(1, 3'd4, 2'b01, 32'h0000001F, e, d);
    check("R8 running state write err", {31'b0, e}, 32'h1);
    bus(0, 3'd4, 2'b11, 32'h0, e, d);
    check("R8 state read while running", d, 32'h00000007);
    bus(1, 3'd0, 2'b01, 32'h2, e, d);

    // R1: reset in mid run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bus(0, 3'd0, 2'b11, 32'h0, e, d);
    check("R1 ctrl after reset", d, 32'h00030003);
    bus(0, 3'd3, 2'b11, 32'h0, e, d);
    check("R1 count after reset", d, 32'h0);
    bus(0, 3'd1, 2'b11, 32'h0, e, d);
    check("R1 config after reset", d, 32'h0);

    finish_run();
  end
endmodule